// File: doc/BRIEF.md
# TAP Scan Master

This block is the host end of a test access port link. It drives the TCK, TMS and TDI pins and samples TDO so that one command runs one complete scan on a single target TAP. A scan starts with the TAP in Run-Test/Idle and leaves it there again. A command gives one of four kinds:

- an instruction-register scan, which always moves 8 bits;
- a data-register scan of 8 or 16 bits;
- a TAP reset, which first plays a TMS pulse pattern that the target uses for its fuse check;
- a command that sets the level held on the shared test-clock/TDI line between scans.

Every pin step lasts a number of system clocks that the caller programs. When a command finishes, the block returns the bits it captured from TDO, right-aligned, together with a one-cycle done strobe. The block does not translate instruction opcodes. A caller that needs a logical opcode to arrive in the target's bit order reverses it before issuing the command. For example, logical 0x13 is issued as 0xC8.

Top module: `tap_scan_master`

## Requirements
- R1: After reset, cmdReady is 1, rspDone is 0, TCK is 1, TMS is 0, TDI is 0 (the held line level), and rspWord is 0.
- R2: Command kind 2 (TAP reset) plays 19 steps. The first step has TCK=1 and TMS=1. The next four steps keep TCK=1 and set TMS to 0, 1, 0, 1. Then come six TCK pulses with TMS=1, and finally one pulse with TMS=0. A pulse is one step with TCK=0 followed by one step with TCK=1.
- R3: Command kind 1 (instruction scan) gives four pulses with TMS 1, 1, 0, 0 and then shifts exactly 8 bits, whatever cmdLen16 says. The captured bits come back in rspWord[7:0] and the upper bits are 0. For example, an identification value of 0x89 reads back as 0x0089.
- R4: Command kind 0 (data scan) gives three pulses with TMS 1, 0, 0 and then shifts 16 bits when cmdLen16 is 1, or 8 bits when it is 0.
- R5: During the shift, cmdWord goes out on TDI most significant bit first, one bit per pulse. The TDO level present at the end of a pulse's TCK-high step is stored in the matching bit of rspWord. A scan clears all rspWord bits it does not shift.
- R6: TMS is 1 during the pulse of the last data bit. After the shift come one pulse with TMS=1 and then one pulse with TMS=0. Inside a scan, TMS changes only in a step where TCK is 0.
- R7: Outside the shift pulses, TDI carries the held line level. Command kind 3 loads this level from cmdWord[0] and takes one step. The level is restored on TDI after every shift.
- R8: Each step lasts halfPeriod+1 system clocks. halfPeriod is sampled when the command is accepted.
- R9: cmdReady is 0 from acceptance until completion. Commands offered during that time have no effect.
- R10: In the clock after the last step, rspDone is 1 for exactly one cycle and cmdReady is 1 again. The pins are back at TCK=1, TMS=0 and TDI at the line level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Engine idle, command taken when cmdValid is 1 |
| cmdKind | input | 2 | 0 data scan, 1 instruction scan, 2 TAP reset, 3 set line level |
| cmdLen16 | input | 1 | Data scan length: 1 for 16 bits, 0 for 8 bits |
| cmdWord | input | 16 | Shift word, or new line level in bit 0 |
| halfPeriod | input | 8 | Step length minus one, in system clocks |
| rspWord | output | 16 | Bits captured from TDO, right-aligned |
| rspDone | output | 1 | One-cycle completion strobe |
| tapTck | output | 1 | Test clock pin |
| tapTms | output | 1 | Mode select pin |
| tapTdi | output | 1 | Data pin, shared with the held test-clock level |
| tapTdo | input | 1 | Data returned from the target |

## Verification
The hardest case to reach from the ports is a command that is offered while the engine is busy. A correct design shows no trace of it. To get there, the stimulus keeps cmdValid high for the whole run of several commands. During that time it changes the kind, word, length and halfPeriod inputs, and drops cmdValid only in the final step. Any late latch of those inputs then shows up as a wrong step length or a wrong pin pattern. The bench drives TDO from its own expected step list, so any timing error in the capture shows up as wrong bits in rspWord.

// File: rtl/tap_scan_pkg.sv
package tap_scan_pkg;
  localparam int DATA_W = 16;
  localparam int SHORT_W = DATA_W / 2;
  localparam int IDX_W = $clog2(DATA_W);

  typedef enum logic [1:0] {
    CMD_DR    = 2'd0,
    CMD_IR    = 2'd1,
    CMD_RESET = 2'd2,
    CMD_LEVEL = 2'd3
  } cmdKind_e;

  typedef struct packed {
    logic             load;
    logic             setLevel;
    logic             shiftOn;
    logic             sample;
    logic [IDX_W-1:0] bitIdx;
  } dpCtrl_t;
endpackage

// File: rtl/tap_scan_ctrl.sv
module tap_scan_ctrl import tap_scan_pkg::*; #(
  parameter int DIV_W = 8,
  parameter int IR_PRE = 4,
  parameter int DR_PRE = 3,
  parameter int POST = 2,
  parameter int RST_PULSES = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  cmdKind_e         cmdKind,
  input  logic             cmdLen16,
  input  logic [DIV_W-1:0] halfPeriod,
  output logic             cmdReady,
  output logic             tckOut,
  output logic             tmsOut,
  output dpCtrl_t          dpCtl,
  output logic             doneStb
);
  localparam int PH_W = $clog2(2 * (IR_PRE + DATA_W + POST) + 1);
  localparam int FUSE_STEPS = 4;
  localparam int PULSE_START = 1 + FUSE_STEPS;
  localparam int PULSE_END = PULSE_START + 2 * RST_PULSES;
  localparam int RESET_LAST = PULSE_END + 1;

  logic             busy;
  cmdKind_e         kindQ;
  logic             len16Q;
  logic [PH_W-1:0]  phaseCnt;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfQ;

  logic             accept;
  logic             tick;
  logic             half;
  logic [PH_W-1:0]  pulseIdx;
  logic [PH_W-1:0]  preLen;
  logic [PH_W-1:0]  nBits;
  logic [PH_W-1:0]  lastPhase;
  logic             shiftOn;
  logic [IDX_W-1:0] bitIdx;

  assign accept   = cmdValid && !busy;
  assign tick     = busy && (divCnt == halfQ);
  assign half     = phaseCnt[0];
  assign pulseIdx = phaseCnt >> 1;
  assign cmdReady = !busy;

  always_comb begin
    tckOut    = 1'b1;
    tmsOut    = 1'b0;
    shiftOn   = 1'b0;
    bitIdx    = '0;
    lastPhase = '0;
    preLen    = (kindQ == CMD_IR) ? PH_W'(IR_PRE) : PH_W'(DR_PRE);
    nBits     = (kindQ == CMD_IR || !len16Q) ? PH_W'(SHORT_W) : PH_W'(DATA_W);
    if (busy) begin
      case (kindQ)
        CMD_DR, CMD_IR: begin
          lastPhase = PH_W'(2 * (preLen + nBits + PH_W'(POST)) - 1);
          tckOut    = half;
          if (pulseIdx < preLen) begin
            tmsOut = (kindQ == CMD_IR) ? (pulseIdx < PH_W'(2)) : (pulseIdx == '0);
          end else if (pulseIdx < preLen + nBits) begin
            shiftOn = 1'b1;
            bitIdx  = IDX_W'(nBits - PH_W'(1) - (pulseIdx - preLen));
            tmsOut  = (pulseIdx == preLen + nBits - PH_W'(1));
          end else begin
            tmsOut = (pulseIdx == preLen + nBits);
          end
        end
        CMD_RESET: begin
          lastPhase = PH_W'(RESET_LAST);
          if (phaseCnt == '0) begin
            tmsOut = 1'b1;
          end else if (phaseCnt <= PH_W'(FUSE_STEPS)) begin
            tmsOut = !phaseCnt[0];
          end else begin
            tckOut = !phaseCnt[0];
            tmsOut = (phaseCnt < PH_W'(PULSE_END));
          end
        end
        default: lastPhase = '0;
      endcase
    end
  end

  always_comb begin
    dpCtl.load     = accept && (cmdKind == CMD_DR || cmdKind == CMD_IR);
    dpCtl.setLevel = accept && (cmdKind == CMD_LEVEL);
    dpCtl.shiftOn  = shiftOn;
    dpCtl.sample   = tick && shiftOn && half;
    dpCtl.bitIdx   = bitIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      kindQ    <= CMD_DR;
      len16Q   <= 1'b0;
      phaseCnt <= '0;
      divCnt   <= '0;
      halfQ    <= '0;
      doneStb  <= 1'b0;
    end else begin
      doneStb <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        kindQ    <= cmdKind;
        len16Q   <= cmdLen16;
        halfQ    <= halfPeriod;
        phaseCnt <= '0;
        divCnt   <= '0;
      end else if (busy) begin
        if (tick) begin
          divCnt <= '0;
          if (phaseCnt == lastPhase) begin
            busy    <= 1'b0;
            doneStb <= 1'b1;
          end else begin
            phaseCnt <= phaseCnt + PH_W'(1);
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb);
  assert_div_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> divCnt <= halfQ);
  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> phaseCnt <= lastPhase);
  assert_hold_cmd_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(tick && phaseCnt == lastPhase)) |=> ($stable(kindQ) && $stable(halfQ) && $stable(len16Q)));
  assert_tms_low_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && kindQ != CMD_RESET && kindQ != CMD_LEVEL && tmsOut != $past(tmsOut)) |-> !tckOut);
endmodule

// File: rtl/tap_scan_dp.sv
module tap_scan_dp import tap_scan_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtl,
  input  logic [DATA_W-1:0] cmdWord,
  input  logic              tdoIn,
  output logic              tdiOut,
  output logic [DATA_W-1:0] capWord
);
  logic [DATA_W-1:0] wordQ;
  logic [DATA_W-1:0] capQ;
  logic              lineLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ   <= '0;
      capQ    <= '0;
      lineLvl <= 1'b0;
    end else begin
      if (dpCtl.load) begin
        wordQ <= cmdWord;
        capQ  <= '0;
      end else if (dpCtl.sample) begin
        capQ[dpCtl.bitIdx] <= tdoIn;
      end
      if (dpCtl.setLevel) lineLvl <= cmdWord[0];
    end
  end

  assign tdiOut  = dpCtl.shiftOn ? wordQ[dpCtl.bitIdx] : lineLvl;
  assign capWord = capQ;

  assert_level_take_R7: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.setLevel |=> lineLvl == $past(cmdWord[0]));
  assert_cap_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.load |=> capQ == '0);
endmodule

// File: rtl/tap_scan_master.sv
module tap_scan_master import tap_scan_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdKind,
  input  logic              cmdLen16,
  input  logic [DATA_W-1:0] cmdWord,
  input  logic [DIV_W-1:0]  halfPeriod,
  output logic [DATA_W-1:0] rspWord,
  output logic              rspDone,
  output logic              tapTck,
  output logic              tapTms,
  output logic              tapTdi,
  input  logic              tapTdo
);
  dpCtrl_t dpCtl;

  tap_scan_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind_e'(cmdKind)),
    .cmdLen16(cmdLen16), .halfPeriod(halfPeriod), .cmdReady(cmdReady),
    .tckOut(tapTck), .tmsOut(tapTms), .dpCtl(dpCtl), .doneStb(rspDone)
  );

  tap_scan_dp uDp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .cmdWord(cmdWord),
    .tdoIn(tapTdo), .tdiOut(tapTdi), .capWord(rspWord)
  );
endmodule

// File: tb/tb_tap_scan_master.sv
`timescale 1ns/1ps
module tb_tap_scan_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [1:0]  cmdKind = 2'd0;
  logic        cmdLen16 = 1'b0;
  logic [15:0] cmdWord = 16'h0;
  logic [7:0]  halfPeriod = 8'd0;
  logic [15:0] rspWord;
  logic        rspDone;
  logic        tapTck, tapTms, tapTdi;
  logic        tapTdo = 1'b0;

  int errs = 0;
  int checks = 0;
  bit finished = 0;
  bit lvl = 0;
  logic [3:0] expQ[$];

  always #2 clk = ~clk;

  tap_scan_master dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdKind(cmdKind), .cmdLen16(cmdLen16), .cmdWord(cmdWord),
    .halfPeriod(halfPeriod), .rspWord(rspWord), .rspDone(rspDone),
    .tapTck(tapTck), .tapTms(tapTms), .tapTdi(tapTdi), .tapTdo(tapTdo)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] x);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = x[7-i];
    return r;
  endfunction

  // entry = {tck, tms, tdi, tdo driven by the bench}
  task automatic pushPulse(input bit m, input bit d, input bit t);
    expQ.push_back({1'b0, m, d, t});
    expQ.push_back({1'b1, m, d, t});
  endtask

  task automatic buildScan(input bit ir, input int n, input logic [15:0] w, input logic [15:0] pat);
    if (ir) begin
      pushPulse(1, lvl, 0); pushPulse(1, lvl, 0); pushPulse(0, lvl, 0); pushPulse(0, lvl, 0);
    end else begin
      pushPulse(1, lvl, 0); pushPulse(0, lvl, 0); pushPulse(0, lvl, 0);
    end
    for (int i = n - 1; i >= 0; i--) pushPulse(i == 0, w[i], pat[i]);
    pushPulse(1, lvl, 0);
    pushPulse(0, lvl, 0);
  endtask

  task automatic buildReset();
    expQ.push_back({1'b1, 1'b1, lvl, 1'b0});
    expQ.push_back({1'b1, 1'b0, lvl, 1'b0});
    expQ.push_back({1'b1, 1'b1, lvl, 1'b0});
    expQ.push_back({1'b1, 1'b0, lvl, 1'b0});
    expQ.push_back({1'b1, 1'b1, lvl, 1'b0});
    for (int i = 0; i < 6; i++) pushPulse(1, lvl, 0);
    pushPulse(0, lvl, 0);
  endtask

  task automatic runCmd(input logic [1:0] kind, input bit len16, input logic [15:0] word,
                        input int hp, input bit pester, input logic [15:0] expRsp, input string tag);
    int total;
    int n;
    logic [3:0] e;
    cmdKind = kind; cmdLen16 = len16; cmdWord = word; halfPeriod = 8'(hp); cmdValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    total = expQ.size() * (hp + 1);
    n = 0;
    for (int k = 0; k < expQ.size(); k++) begin
      for (int c = 0; c <= hp; c++) begin
        e = expQ[k];
        tapTdo = e[0];
        chk($sformatf("%s step%0d", tag, k), {27'd0, tapTck, tapTms, tapTdi, cmdReady, rspDone},
            {27'd0, e[3], e[2], e[1], 1'b0, 1'b0});
        n++;
        if (pester && n < total) begin
          cmdValid = 1'b1; cmdKind = ~kind; cmdWord = ~word;
          cmdLen16 = ~len16; halfPeriod = 8'(hp + 3);
        end else begin
          cmdValid = 1'b0;
        end
        @(negedge clk);
      end
    end
    chk({tag, " R10 done"}, {27'd0, tapTck, tapTms, tapTdi, cmdReady, rspDone},
        {27'd0, 1'b1, 1'b0, lvl, 1'b1, 1'b1});
    chk({tag, " R5 result"}, {16'd0, rspWord}, {16'd0, expRsp});
    @(negedge clk);
    chk({tag, " R10 single"}, {31'd0, rspDone}, 32'd0);
    expQ.delete();
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset pins", {28'd0, tapTck, tapTms, tapTdi, cmdReady}, {28'd0, 4'b1001});
    chk("R1 reset done", {31'd0, rspDone}, 32'd0);
    chk("R1 reset word", {16'd0, rspWord}, 32'd0);

    buildReset();
    runCmd(2'd2, 0, 16'h0, 0, 0, 16'h0, "R2 reset hp0");
    buildReset();
    runCmd(2'd2, 0, 16'h0, 2, 0, 16'h0, "R2 R8 reset hp2");

    buildScan(1, 8, {8'h0, rev8(8'h13)}, 16'h0089);
    runCmd(2'd1, 0, {8'h0, rev8(8'h13)}, 1, 0, 16'h0089, "R3 R5 ir id");
    buildScan(1, 8, {8'h0, rev8(8'h41)}, 16'hFF89);
    runCmd(2'd1, 1, {8'h0, rev8(8'h41)}, 0, 0, 16'h0089, "R3 ir len ignored");

    buildScan(0, 16, 16'h2401, 16'hA5C3);
    runCmd(2'd0, 1, 16'h2401, 0, 0, 16'hA5C3, "R4 R5 R6 dr16");
    buildScan(0, 8, 16'h005A, 16'hFFE7);
    runCmd(2'd0, 0, 16'h005A, 1, 0, 16'h00E7, "R4 R5 dr8");

    lvl = 1;
    expQ.push_back({1'b1, 1'b0, 1'b1, 1'b0});
    runCmd(2'd3, 0, 16'h0001, 0, 0, 16'h00E7, "R7 level high");
    buildScan(0, 16, 16'h0F0F, 16'h1234);
    runCmd(2'd0, 1, 16'h0F0F, 2, 1, 16'h1234, "R7 R8 R9 dr16 busy");
    buildScan(1, 8, 16'h00C8, 16'h0055);
    runCmd(2'd1, 0, 16'h00C8, 3, 1, 16'h0055, "R7 R9 ir busy");

    lvl = 0;
    expQ.push_back({1'b1, 1'b0, 1'b0, 1'b0});
    runCmd(2'd3, 0, 16'hFFFE, 1, 0, 16'h0055, "R7 level low");
    buildReset();
    runCmd(2'd2, 0, 16'hFFFF, 1, 1, 16'h0055, "R2 R9 reset busy");
    buildScan(0, 8, 16'h00FF, 16'h0000);
    runCmd(2'd0, 0, 16'h00FF, 0, 0, 16'h0000, "R6 R7 dr8 restore");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule